// File: doc/BRIEF.md
# Ping-Pong Binary-Search Phase Matcher

This block finds, for each rectified camera pixel, the sub-pixel column of the projector reference line whose phase equals the pixel's phase. Reference lines increase strictly along the line. They arrive one word per accepted transfer on a ready/valid port and are written into the fill half of a two-bank line store. Meanwhile the other bank serves as the lookup table for the pixels being matched. A `line_swap` pulse exchanges the two banks once the fill bank holds a complete line.

Pixels arrive at up to one per clock. A round-robin pointer hands each pixel to one of `NU = log2(WIDTH) + 1` identical match units. Each unit has its own read port into the line store. It spends `log2(WIDTH)` clocks on a binary search for the bracketing pair of entries and one clock on linear interpolation between them. Every unit takes exactly `NU` clocks, so the units finish in the order the pixels were accepted. The output stage picks whichever unit finishes in a given cycle, and results therefore leave in pixel order.

The loader state machine has three states:
- `LD_FILL`: ready is high and words are accepted. It moves to `LD_FULL` when the last word of the line is written.
- `LD_FULL`: ready is low. It moves to `LD_DRAIN` on an accepted swap.
- `LD_DRAIN`: lasts `NU` clocks, so that units still reading the retired bank can finish. It then returns to `LD_FILL`.

Each match unit has three states:
- `MU_IDLE`: moves to `MU_SEEK` on start.
- `MU_SEEK`: one search step per clock. It moves to `MU_FINISH` after the last step.
- `MU_FINISH`: interpolates and emits the result. It moves to `MU_SEEK` on a new start, otherwise to `MU_IDLE`.

Top module: `phase_matcher`

## Requirements
- R1: After reset, `ref_ready` is 1 and `res_valid` is 0.
- R2: In the fill state exactly `WIDTH` words are accepted, at entries 0 to `WIDTH-1`. After the last one `ref_ready` is 0 until a swap is accepted, and words offered while it is 0 are not stored.
- R3: A `line_swap` pulse while the fill bank is not yet complete is ignored. `ref_ready` stays 1 and pixels keep matching the previously searched line.
- R4: After an accepted swap `ref_ready` is 0 for exactly `NU` cycles and then returns to 1.
- R5: Pixels accepted before the first accepted swap give `res_hit` = 0.
- R6: Every pixel accepted with `pix_valid` = 1 yields exactly one result. `res_valid` rises `NU` clocks after the accepting edge, results keep the order of acceptance, and one pixel per clock is sustained.
- R7: `res_col` is `AW+8` bits. Its upper `AW` bits hold the largest index i with ref[i] <= phase. Its low 8 bits hold floor(256*(phase-ref[i])/(ref[i+1]-ref[i])).
- R8: A phase equal to the last entry gives `res_hit` = 1 and `res_col` = {WIDTH-1, 8'd0}.
- R9: A phase below entry 0 or above entry `WIDTH-1` gives `res_hit` = 0 and `res_col` = 0.
- R10: A pixel with `pix_snr_ok` = 0 gives `res_hit` = 0 and `res_col` = 0.
- R11: A pixel accepted on the same edge as an accepted swap is matched against the old line. Pixels accepted later are matched against the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference word offered |
| ref_phase | input | PW | Reference phase word |
| ref_ready | output | 1 | Fill bank accepts a word |
| line_swap | input | 1 | Request to exchange fill and search banks |
| pix_valid | input | 1 | Pixel presented this cycle |
| pix_phase | input | PW | Pixel's unwrapped phase |
| pix_snr_ok | input | 1 | Pixel's signal quality is usable |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Result carries a usable match |
| res_col | output | AW+FB | Fixed-point matched column, FB fractional bits |

## Verification
The checker watches several properties on every clock:
- the count of accepted reference words never exceeds a line while ready is high;
- ready stays low through the drain window;
- no unit is started while it is searching;
- at most one unit finishes per cycle;
- each result appears exactly `NU` clocks after its pixel, and a low-quality pixel never yields a hit;
- a miss carries a zero column, and an exact match on the last entry has a zero fraction.

The numeric column values, and which line a pixel is matched against around a swap, can only be shown by the bench's scenarios. The same holds for ignored swaps and for refused words never reaching the store. The bench compares each result against columns it computes from its own copy of the reference lines.

// File: rtl/phm_pkg.sv
package phm_pkg;

    typedef enum logic [1:0] {
        LD_FILL  = 2'd0,
        LD_FULL  = 2'd1,
        LD_DRAIN = 2'd2
    } ld_state_e;

    typedef enum logic [1:0] {
        MU_IDLE   = 2'd0,
        MU_SEEK   = 2'd1,
        MU_FINISH = 2'd2
    } mu_state_e;

endpackage

// File: rtl/phm_loader.sv
module phm_loader
    import phm_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int PW    = 16,
    parameter int NU    = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ref_valid,
    input  logic [PW-1:0]                    ref_phase,
    output logic                             ref_ready,
    input  logic                             line_swap,
    output logic                             swap_acc,
    output logic                             srch_bank,
    output logic                             srch_ok,
    output logic [1:0][WIDTH-1:0][PW-1:0]    lines
);
    localparam int AW = $clog2(WIDTH);
    localparam int DW = (NU > 1) ? $clog2(NU) : 1;
    localparam logic [AW-1:0] LAST = AW'(WIDTH - 1);

    ld_state_e     st, st_nx;
    logic          ld_bank;
    logic [AW-1:0] wr_ptr;
    logic [DW-1:0] drain_cnt;
    logic          wr_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= LD_FILL;
        else        st <= st_nx;
    end

    // next state and outputs
    always_comb begin
        st_nx     = st;
        ref_ready = 1'b0;
        swap_acc  = 1'b0;
        unique case (st)
            LD_FILL: begin
                ref_ready = 1'b1;
                if (ref_valid && wr_ptr == LAST) st_nx = LD_FULL;
            end
            LD_FULL: begin
                if (line_swap) begin
                    swap_acc = 1'b1;
                    st_nx    = LD_DRAIN;
                end
            end
            LD_DRAIN: begin
                if (drain_cnt == '0) st_nx = LD_FILL;
            end
            default: st_nx = LD_FILL;
        endcase
    end

    assign wr_en     = ref_ready && ref_valid;
    assign srch_bank = ~ld_bank;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_bank   <= 1'b0;
            wr_ptr    <= '0;
            drain_cnt <= '0;
            srch_ok   <= 1'b0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (swap_acc) begin
                ld_bank   <= ~ld_bank;
                srch_ok   <= 1'b1;
                drain_cnt <= DW'(NU - 1);
            end else if (st == LD_DRAIN && drain_cnt != '0) begin
                drain_cnt <= drain_cnt - 1'b1;
            end
        end
    end

    // line store, no reset: contents are only read after a full fill
    always_ff @(posedge clk) begin
        if (wr_en) lines[ld_bank][wr_ptr] <= ref_phase;
    end

endmodule

// File: rtl/phm_unit.sv
module phm_unit
    import phm_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int PW    = 16,
    parameter int FB    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [PW-1:0]                    pix_phase,
    input  logic                             pix_snr_ok,
    input  logic                             line_ok,
    input  logic                             sel_bank,
    input  logic [1:0][WIDTH-1:0][PW-1:0]    lines,
    output logic                             busy,
    output logic                             done,
    output logic                             hit,
    output logic [$clog2(WIDTH)+FB-1:0]      col
);
    localparam int AW = $clog2(WIDTH);
    localparam int QW = PW + FB;
    localparam logic [AW-1:0] LAST      = AW'(WIDTH - 1);
    localparam logic [AW-1:0] PROBE_TOP = AW'(1) << (AW - 1);
    localparam logic [QW-1:0] FMAX      = QW'((1 << FB) - 1);

    mu_state_e     st, st_nx;
    logic [PW-1:0] ph;
    logic          bank;
    logic [AW-1:0] idx, probe, cand, idx_up;
    logic          ok;

    logic [PW-1:0] cand_val, lo, hi, span, diff, first_val, last_val;
    logic [QW-1:0] num, den, quot;
    logic [FB-1:0] frac;
    logic          in_range;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= MU_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            MU_IDLE:   if (start) st_nx = MU_SEEK;
            MU_SEEK:   if (probe == AW'(1)) st_nx = MU_FINISH;
            MU_FINISH: st_nx = start ? MU_SEEK : MU_IDLE;
            default:   st_nx = MU_IDLE;
        endcase
    end

    assign busy = (st == MU_SEEK);

    // private read port into the line store
    always_comb begin
        cand      = idx | probe;
        idx_up    = (idx == LAST) ? idx : idx + 1'b1;
        cand_val  = lines[bank][cand];
        lo        = lines[bank][idx];
        hi        = lines[bank][idx_up];
        first_val = lines[sel_bank][0];
        last_val  = lines[sel_bank][WIDTH-1];
        in_range  = (pix_phase >= first_val) && (pix_phase <= last_val);
        span      = hi - lo;
        diff      = ph - lo;
        num       = {diff, {FB{1'b0}}};
        den       = {{FB{1'b0}}, span};
        quot      = (span == '0) ? '0 : num / den;
        frac      = (quot > FMAX) ? FMAX[FB-1:0] : quot[FB-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= '0;
            bank  <= 1'b0;
            idx   <= '0;
            probe <= '0;
            ok    <= 1'b0;
            done  <= 1'b0;
            hit   <= 1'b0;
            col   <= '0;
        end else begin
            if (start) begin
                ph    <= pix_phase;
                bank  <= sel_bank;
                idx   <= '0;
                probe <= PROBE_TOP;
                ok    <= pix_snr_ok && line_ok && in_range;
            end else if (st == MU_SEEK) begin
                if (cand_val <= ph) idx <= cand;
                probe <= probe >> 1;
            end
            done <= (st == MU_FINISH);
            if (st == MU_FINISH) begin
                hit <= ok;
                col <= ok ? {idx, frac} : '0;
            end
        end
    end

endmodule

// File: rtl/phase_matcher.sv
module phase_matcher
    import phm_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int PW    = 16,
    parameter int FB    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ref_valid,
    input  logic [PW-1:0]               ref_phase,
    output logic                        ref_ready,
    input  logic                        line_swap,
    input  logic                        pix_valid,
    input  logic [PW-1:0]               pix_phase,
    input  logic                        pix_snr_ok,
    output logic                        res_valid,
    output logic                        res_hit,
    output logic [$clog2(WIDTH)+FB-1:0] res_col
);
    localparam int AW = $clog2(WIDTH);
    localparam int NU = AW + 1;
    localparam int CW = AW + FB;
    localparam int RW = $clog2(NU);

    logic                          swap_acc, srch_bank, srch_ok;
    logic [1:0][WIDTH-1:0][PW-1:0] lines;
    logic [RW-1:0]                 rr;
    logic [NU-1:0]                 u_start, u_busy, u_done, u_hit;
    logic [NU-1:0][CW-1:0]         u_col;

    phm_loader #(.WIDTH(WIDTH), .PW(PW), .NU(NU)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_phase(ref_phase), .ref_ready(ref_ready),
        .line_swap(line_swap), .swap_acc(swap_acc),
        .srch_bank(srch_bank), .srch_ok(srch_ok), .lines(lines)
    );

    // round-robin dispatch pointer, advances once per accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n)         rr <= '0;
        else if (pix_valid) rr <= (rr == RW'(NU - 1)) ? '0 : rr + 1'b1;
    end

    for (genvar g = 0; g < NU; g++) begin : g_unit
        assign u_start[g] = pix_valid && (rr == RW'(g));
        phm_unit #(.WIDTH(WIDTH), .PW(PW), .FB(FB)) u_mu (
            .clk(clk), .rst_n(rst_n),
            .start(u_start[g]), .pix_phase(pix_phase), .pix_snr_ok(pix_snr_ok),
            .line_ok(srch_ok), .sel_bank(srch_bank), .lines(lines),
            .busy(u_busy[g]), .done(u_done[g]), .hit(u_hit[g]), .col(u_col[g])
        );
    end

    // equal latency in every unit keeps the finishing order equal to pixel order
    always_comb begin
        res_valid = 1'b0;
        res_hit   = 1'b0;
        res_col   = '0;
        for (int k = 0; k < NU; k++) begin
            if (u_done[k]) begin
                res_valid = 1'b1;
                res_hit   = u_hit[k];
                res_col   = u_col[k];
            end
        end
    end

endmodule

// File: rtl/phm_checker.sv
module phm_checker #(
    parameter int WIDTH = 16,
    parameter int NU    = 5,
    parameter int CW    = 12,
    parameter int FB    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_valid,
    input logic          ref_ready,
    input logic          swap_acc,
    input logic          pix_valid,
    input logic          pix_snr_ok,
    input logic [NU-1:0] u_start,
    input logic [NU-1:0] u_busy,
    input logic [NU-1:0] u_done,
    input logic          res_valid,
    input logic          res_hit,
    input logic [CW-1:0] res_col
);
    localparam int FCW = $clog2(WIDTH + 1);
    localparam int DCW = $clog2(NU + 1);

    logic [FCW-1:0] fcnt;
    logic [DCW-1:0] dcnt;
    logic [NU:0]    acc_pipe, snr_pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt     <= '0;
            dcnt     <= '0;
            acc_pipe <= '0;
            snr_pipe <= '0;
        end else begin
            if (swap_acc)                    fcnt <= '0;
            else if (ref_valid && ref_ready) fcnt <= fcnt + 1'b1;
            if (swap_acc)                    dcnt <= DCW'(NU);
            else if (dcnt != '0)             dcnt <= dcnt - 1'b1;
            acc_pipe <= {acc_pipe[NU-1:0], pix_valid};
            snr_pipe <= {snr_pipe[NU-1:0], pix_snr_ok};
        end
    end

    // R2: never ready once a whole line has been taken
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ready |-> (fcnt < FCW'(WIDTH)));

    // R4: ready held low through the drain window
    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dcnt != '0) |-> !ref_ready);

    // R6: a unit is never restarted mid-search
    p_start_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (u_start & u_busy) == '0);

    // R6: at most one finishing unit per cycle
    p_one_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(u_done));

    // R6: fixed latency, one result per accepted pixel
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == acc_pipe[NU]);

    // R10: low-quality pixel never yields a hit
    p_snr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pipe[NU] && !snr_pipe[NU]) |-> !res_hit);

    // R9: a miss carries a zero column
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_col == '0));

    // R8: a match on the last entry has no fraction
    p_last_frac_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit && res_col[CW-1:FB] == (CW-FB)'(WIDTH - 1))
            |-> (res_col[FB-1:0] == '0));

endmodule

bind phase_matcher phm_checker #(.WIDTH(WIDTH), .NU(NU), .CW(CW), .FB(FB)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .swap_acc(swap_acc), .pix_valid(pix_valid), .pix_snr_ok(pix_snr_ok),
    .u_start(u_start), .u_busy(u_busy), .u_done(u_done),
    .res_valid(res_valid), .res_hit(res_hit), .res_col(res_col)
);

// File: tb/tb_phase_matcher.sv
module tb_phase_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int PWB = 16;
    localparam int FBB = 8;
    localparam int AWB = $clog2(W);
    localparam int NB  = AWB + 1;
    localparam int CWB = AWB + FBB;
    localparam int LAT = NB + 2;   // negedge samples from drive point to result

    logic clk = 1'b0;
    logic rst_n;
    logic ref_valid, line_swap, pix_valid, pix_snr_ok;
    logic [PWB-1:0] ref_phase, pix_phase;
    logic ref_ready, res_valid, res_hit;
    logic [CWB-1:0] res_col;

    int total = 0;
    int bad   = 0;
    int ncnt  = 0;
    int cur   = 0;   // line now searched: 0 none, 1 A, 2 B

    int    q_col[$];
    int    q_hit[$];
    int    q_stamp[$];
    string q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_matcher #(.WIDTH(W), .PW(PWB), .FB(FBB)) dut (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_phase(ref_phase), .ref_ready(ref_ready),
        .line_swap(line_swap),
        .pix_valid(pix_valid), .pix_phase(pix_phase), .pix_snr_ok(pix_snr_ok),
        .res_valid(res_valid), .res_hit(res_hit), .res_col(res_col)
    );

    task automatic chk(input bit cond, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ref_at(input int ln, input int i);
        if (ln == 1) return 1000 + 300 * i + 7 * i * i;
        return 500 + 517 * i;
    endfunction

    function automatic int model_hit(input int ln, input int ph, input bit snr);
        if (!snr || ln == 0) return 0;
        if (ph < ref_at(ln, 0) || ph > ref_at(ln, W - 1)) return 0;
        return 1;
    endfunction

    function automatic int model_col(input int ln, input int ph, input bit snr);
        int i;
        if (model_hit(ln, ph, snr) == 0) return 0;
        i = 0;
        for (int j = 0; j < W; j++) if (ref_at(ln, j) <= ph) i = j;
        if (i == W - 1) return i * 256;
        return i * 256 + ((ph - ref_at(ln, i)) * 256) / (ref_at(ln, i + 1) - ref_at(ln, i));
    endfunction

    // result monitor: order, latency and value of every result
    always @(negedge clk) begin
        ncnt++;
        if (res_valid) begin
            if (q_col.size() == 0) begin
                chk(1'b0, "R6", "unexpected result", 1, 0);
            end else begin
                int    ec, eh, es;
                string et;
                ec = q_col.pop_front();
                eh = q_hit.pop_front();
                es = q_stamp.pop_front();
                et = q_tag.pop_front();
                chk(ncnt - es == LAT, "R6", "latency", ncnt - es, LAT);
                chk(int'(res_hit) == eh, et, "hit", int'(res_hit), eh);
                chk(int'(res_col) == ec, et, "col", int'(res_col), ec);
            end
        end
    end

    task automatic drive_pix(input int ph, input bit snr, input bit swp, input string tag);
        @(posedge clk); #1;
        pix_valid  = 1'b1;
        pix_phase  = PWB'(ph);
        pix_snr_ok = snr;
        line_swap  = swp;
        q_col.push_back(model_col(cur, ph, snr));
        q_hit.push_back(model_hit(cur, ph, snr));
        q_stamp.push_back(ncnt);
        q_tag.push_back(tag);
    endtask

    task automatic pix_idle();
        @(posedge clk); #1;
        pix_valid = 1'b0;
        line_swap = 1'b0;
    endtask

    task automatic load_words(input int ln, input int from, input int upto);
        for (int i = from; i <= upto; i++) begin
            @(posedge clk); #1;
            chk(ref_ready == 1'b1, "R2", "ready during fill", int'(ref_ready), 1);
            ref_valid = 1'b1;
            ref_phase = PWB'(ref_at(ln, i));
        end
        @(posedge clk); #1;
        ref_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ref_valid = 1'b0; ref_phase = '0; line_swap = 1'b0;
        pix_valid = 1'b0; pix_phase = '0; pix_snr_ok = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk(ref_ready == 1'b1, "R1", "ready after reset", int'(ref_ready), 1);
        chk(res_valid == 1'b0, "R1", "no result after reset", int'(res_valid), 0);
    endtask

    task automatic t_ignored_swap();
        @(posedge clk); #1 line_swap = 1'b1;
        @(posedge clk); #1 line_swap = 1'b0;
        chk(ref_ready == 1'b1, "R3", "ready after early swap", int'(ref_ready), 1);
    endtask

    task automatic t_full_and_refuse();
        chk(ref_ready == 1'b0, "R2", "ready after full line", int'(ref_ready), 0);
        ref_valid = 1'b1;
        ref_phase = 16'hFFFF;   // must never reach the store
        repeat (3) @(posedge clk);
        #1 ref_valid = 1'b0;
        chk(ref_ready == 1'b0, "R2", "ready while full", int'(ref_ready), 0);
    endtask

    task automatic t_swap(input int newline);
        @(posedge clk); #1 line_swap = 1'b1;
        for (int j = 0; j < NB; j++) begin
            @(posedge clk); #1 line_swap = 1'b0;
            chk(ref_ready == 1'b0, "R4", "ready in drain", int'(ref_ready), 0);
        end
        @(posedge clk); #1;
        chk(ref_ready == 1'b1, "R4", "ready after drain", int'(ref_ready), 1);
        cur = newline;
    endtask

    task automatic t_stream_a();
        for (int i = 0; i < 20; i++) drive_pix(1000 + i * 313 + (i % 3) * 17, 1'b1, 1'b0, "R7");
        for (int i = 0; i < W; i += 5) drive_pix(ref_at(1, i), 1'b1, 1'b0, "R7");
        pix_idle();
    endtask

    task automatic t_edges();
        drive_pix(ref_at(1, W - 1), 1'b1, 1'b0, "R8");
        drive_pix(ref_at(1, 0) - 1, 1'b1, 1'b0, "R9");
        drive_pix(ref_at(1, W - 1) + 1, 1'b1, 1'b0, "R9");
        drive_pix(0, 1'b1, 1'b0, "R9");
        drive_pix(65535, 1'b1, 1'b0, "R9");
        drive_pix(3000, 1'b0, 1'b0, "R10");
        drive_pix(ref_at(1, 4), 1'b0, 1'b0, "R10");
        pix_idle();
    endtask

    task automatic t_switch_b();
        load_words(2, 0, 7);
        t_ignored_swap();
        drive_pix(2500, 1'b1, 1'b0, "R3");
        drive_pix(5000, 1'b1, 1'b0, "R3");
        pix_idle();
        load_words(2, 8, W - 1);
        drive_pix(3000, 1'b1, 1'b1, "R11");   // same edge as accepted swap: old line
        cur = 2;
        drive_pix(3000, 1'b1, 1'b0, "R11");
        for (int i = 0; i < 20; i++) drive_pix(600 + i * 401, 1'b1, 1'b0, "R11");
        pix_idle();
    endtask

    initial begin : main
        t_reset();
        load_words(1, 0, 7);
        t_ignored_swap();
        drive_pix(2000, 1'b1, 1'b0, "R5");
        drive_pix(4000, 1'b1, 1'b0, "R5");
        pix_idle();
        load_words(1, 8, W - 1);
        t_full_and_refuse();
        t_swap(1);
        t_stream_a();
        t_edges();
        t_switch_b();
        repeat (3 * NB) @(posedge clk);
        #1 chk(q_col.size() == 0, "R6", "results outstanding", q_col.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule